// File: doc/BRIEF.md
# Shared Partitioned MAC FIFO

This block is the word buffer between a system bus and an Ethernet MAC. One memory of `DEPTH` words, each `DATA_W` bits wide (112 x 32 bits by default, 448 bytes), is split at a movable word boundary. The low words form a receive FIFO and the rest form a transmit FIFO. The buffer only covers bus latency. A frame may be longer than either side, so each side streams words through while keeping just enough state to undo or repeat the frame it is working on.

On the transmit side, words the MAC has read are not freed straight away. They stay held until the MAC either declares the frame finished or releases them early to make room for a long frame. While nothing has been released, a rewind puts the read position back at the first word of the frame, so the frame can be sent again after a collision without refetching it over the bus.

On the receive side, the MAC writes at a speculative position that the bus side cannot see. A commit makes those words readable. A discard (runt or collision) rolls the write position back to the last commit, and no bus read ever sees the dropped words.

Top module: `shared_mac_fifo`

## Requirements
- R1: After reset the receive side owns `DEPTH/2` words (56) and the transmit side owns the rest; both sides report empty, not full and a count of zero.
- R2: Transmit words written from the bus side are returned to the MAC side in write order. `tx_rd_data` is valid, with `tx_rd_valid` high, in the cycle after a read is accepted. A read is accepted only while `tx_avail` is non-zero. `tx_count` gives the words held; `tx_full` is high when it equals the transmit partition size, and writes made then are ignored.
- R3: While the current frame has had no early release, a `tx_rewind` makes the following reads return the frame again from its first held word, with no new bus writes.
- R4: `tx_frame_done` frees every word read so far in the frame (reads accepted before that cycle). `tx_count` drops by that number, and the next word becomes the start of a new frame.
- R5: `tx_release` frees the words read so far in the same way, and marks the frame as not replayable. A later `tx_rewind` then leaves the read position unchanged and raises `tx_rewind_err` for exactly one cycle, the cycle after the request. `tx_frame_done` clears the mark.
- R6: Words the MAC writes to the receive side do not show in `rx_count` or `rx_empty` until `rx_commit`. A write in the same cycle as `rx_commit` is included in that commit.
- R7: `rx_discard` drops every uncommitted receive word, including a write in the same cycle. It takes priority over `rx_commit`, and committed words are not affected.
- R8: Committed receive words are returned to the bus side in order, valid (`rx_rd_valid` high) in the cycle after an accepted read. `rx_full` is high when committed plus uncommitted words fill the receive partition, and MAC writes made then are ignored.
- R9: A write to `cfg_rx_words` takes effect only if the value is between 1 and `DEPTH-1` and the transmit side holds no word and the receive side holds no committed or uncommitted word. Otherwise it is ignored. Once accepted, the receive side owns that many words and the transmit side owns `DEPTH` minus that many.
- R10: Each side's pointers and counts wrap modulo its own partition size, so data stays in order across wraparound with an unequal split.
- R11: In a cycle with `tx_rewind` high, `tx_rd_en`, `tx_frame_done` and `tx_release` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Request to move the partition boundary |
| cfg_rx_words | input | CNT_W | Requested receive partition size in words |
| part_rx_words | output | CNT_W | Receive partition size in force |
| tx_wr_en | input | 1 | Bus-side transmit write |
| tx_wr_data | input | DATA_W | Transmit write word |
| tx_full | output | 1 | Transmit partition completely held |
| tx_empty | output | 1 | Transmit side holds no word |
| tx_count | output | CNT_W | Transmit words held (unread plus read but not freed) |
| tx_rd_en | input | 1 | MAC-side transmit read |
| tx_rd_data | output | DATA_W | Transmit read word |
| tx_rd_valid | output | 1 | `tx_rd_data` carries the word of last cycle's read |
| tx_avail | output | CNT_W | Transmit words not yet read |
| tx_frame_done | input | 1 | Current transmit frame finished; free its read words |
| tx_release | input | 1 | Free read words early; frame loses replay |
| tx_rewind | input | 1 | Restart reading at the current frame start |
| tx_rewind_err | output | 1 | One-cycle pulse: rewind refused |
| rx_wr_en | input | 1 | MAC-side receive write |
| rx_wr_data | input | DATA_W | Receive write word |
| rx_commit | input | 1 | Make uncommitted receive words readable |
| rx_discard | input | 1 | Drop uncommitted receive words |
| rx_full | output | 1 | Receive partition completely used |
| rx_rd_en | input | 1 | Bus-side receive read |
| rx_rd_data | output | DATA_W | Receive read word |
| rx_rd_valid | output | 1 | `rx_rd_data` carries the word of last cycle's read |
| rx_count | output | CNT_W | Committed receive words |
| rx_empty | output | 1 | No committed receive word |

## Verification
The transmit side is driven with a plain write, read and finish pattern, a read, rewind and reread pattern, and a read, early release and refused-rewind pattern. Comparing the words returned across these patterns tells a real replay apart from a stale read pointer or a wrongly freed start. The receive side gets commits with and without a write in the same cycle, and discards alone and together with a commit, which separates speculative words from visible ones. Streams longer than each side, run after an uneven repartition, and boundary writes made while a side is occupied or out of range, show whether the wrap and the lock use the live partition size.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  typedef enum logic [2:0] {
    TXOP_IDLE,
    TXOP_REWIND,
    TXOP_REWIND_ERR,
    TXOP_FREE_DONE,
    TXOP_FREE_PART
  } tx_op_e;

  typedef enum logic [1:0] {
    RXOP_IDLE,
    RXOP_COMMIT,
    RXOP_DROP
  } rx_op_e;

  // Advance an offset inside a region of 'size' words.
  function automatic int unsigned ring_next(input int unsigned off, input int unsigned size);
    return (off + 1 >= size) ? 0 : off + 1;
  endfunction

  // Physical word address of an offset within a region.
  function automatic int unsigned region_addr(input int unsigned base, input int unsigned off);
    return base + off;
  endfunction

  // A boundary value leaves at least one word on each side.
  function automatic bit split_ok(input int unsigned v, input int unsigned depth);
    return (v >= 1) && (v < depth);
  endfunction

endpackage

// File: rtl/sfm_mem.sv
module sfm_mem #(
  parameter int DEPTH  = 112,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wa_en,
  input  logic [AW-1:0]     wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [AW-1:0]     wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              ra_en,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic              rb_en,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // The two write ports always target disjoint regions.
  always_ff @(posedge clk) begin
    if (wa_en) mem[wa_addr] <= wa_data;
    if (wb_en) mem[wb_addr] <= wb_data;
  end

  always_ff @(posedge clk) begin
    if (ra_en) ra_data <= mem[ra_addr];
    if (rb_en) rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/sfm_split.sv
module sfm_split
  import sfm_pkg::*;
#(
  parameter int DEPTH = 112,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  input  logic             tx_idle_i,
  input  logic             rx_idle_i,
  output logic [CNT_W-1:0] rx_words_o,
  output logic [CNT_W-1:0] tx_words_o,
  output logic             part_chg_o
);

  logic [CNT_W-1:0] rx_words_q;

  assign part_chg_o = cfg_wr_i && tx_idle_i && rx_idle_i && split_ok(32'(cfg_val_i), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n)          rx_words_q <= CNT_W'(DEPTH / 2);
    else if (part_chg_o) rx_words_q <= cfg_val_i;
  end

  assign rx_words_o = rx_words_q;
  assign tx_words_o = CNT_W'(DEPTH) - rx_words_q;

  assert_split_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_words_q >= CNT_W'(1)) && (rx_words_q <= CNT_W'(DEPTH - 1)));

endmodule

// File: rtl/sfm_tx_ctrl.sv
module sfm_tx_ctrl
  import sfm_pkg::*;
#(
  parameter int DEPTH = 112,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] size_i,
  input  logic             part_chg_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             done_i,
  input  logic             release_i,
  input  logic             rewind_i,
  output logic             wr_ok_o,
  output logic [PTR_W-1:0] wr_off_o,
  output logic             rd_ok_o,
  output logic [PTR_W-1:0] rd_off_o,
  output logic [CNT_W-1:0] held_o,
  output logic [CNT_W-1:0] avail_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             rewind_err_o
);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, start_ptr_q;
  logic [CNT_W-1:0] held_q, pend_q, held_d, pend_d;
  logic             trimmed_q, rewind_err_q;
  logic             freeing;
  tx_op_e           op;

  // Control priority: rewind, then frame done, then early release.
  always_comb begin
    if (rewind_i)       op = trimmed_q ? TXOP_REWIND_ERR : TXOP_REWIND;
    else if (done_i)    op = TXOP_FREE_DONE;
    else if (release_i) op = TXOP_FREE_PART;
    else                op = TXOP_IDLE;
  end

  assign freeing = (op == TXOP_FREE_DONE) || (op == TXOP_FREE_PART);
  assign wr_ok_o = wr_en_i && !part_chg_i && (held_q != size_i);
  assign rd_ok_o = rd_en_i && !part_chg_i && !rewind_i && (held_q != pend_q);

  always_comb begin
    held_d = held_q - (freeing ? pend_q : '0) + CNT_W'(wr_ok_o);
    if (op == TXOP_REWIND) pend_d = '0;
    else                   pend_d = (freeing ? '0 : pend_q) + CNT_W'(rd_ok_o);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || part_chg_i) begin
      wr_ptr_q     <= '0;
      rd_ptr_q     <= '0;
      start_ptr_q  <= '0;
      held_q       <= '0;
      pend_q       <= '0;
      trimmed_q    <= 1'b0;
      rewind_err_q <= 1'b0;
    end else begin
      held_q <= held_d;
      pend_q <= pend_d;
      if (wr_ok_o) wr_ptr_q <= PTR_W'(ring_next(32'(wr_ptr_q), 32'(size_i)));
      if (op == TXOP_REWIND) rd_ptr_q <= start_ptr_q;
      else if (rd_ok_o)      rd_ptr_q <= PTR_W'(ring_next(32'(rd_ptr_q), 32'(size_i)));
      if (freeing) start_ptr_q <= rd_ptr_q;
      if (op == TXOP_FREE_DONE)      trimmed_q <= 1'b0;
      else if (op == TXOP_FREE_PART) trimmed_q <= 1'b1;
      rewind_err_q <= (op == TXOP_REWIND_ERR);
    end
  end

  assign wr_off_o     = wr_ptr_q;
  assign rd_off_o     = rd_ptr_q;
  assign held_o       = held_q;
  assign avail_o      = held_q - pend_q;
  assign full_o       = (held_q == size_i);
  assign empty_o      = (held_q == '0);
  assign rewind_err_o = rewind_err_q;

  assert_tx_hold_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    held_q <= size_i);

  assert_tx_pend_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= held_q);

  assert_tx_replay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TXOP_REWIND && !part_chg_i) |=>
      (pend_q == '0) && (held_q == $past(held_q) + CNT_W'($past(wr_ok_o))));

  assert_tx_err_keeps_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_err_q && !$past(part_chg_i)) |-> ($stable(rd_ptr_q) && $stable(pend_q)));

  assert_tx_rewind_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_i |-> !rd_ok_o);

endmodule

// File: rtl/sfm_rx_ctrl.sv
module sfm_rx_ctrl
  import sfm_pkg::*;
#(
  parameter int DEPTH = 112,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] size_i,
  input  logic             part_chg_i,
  input  logic             wr_en_i,
  input  logic             commit_i,
  input  logic             discard_i,
  input  logic             rd_en_i,
  output logic             wr_ok_o,
  output logic [PTR_W-1:0] wr_off_o,
  output logic             rd_ok_o,
  output logic [PTR_W-1:0] rd_off_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] spec_o,
  output logic             full_o,
  output logic             empty_o
);

  logic [PTR_W-1:0] spec_ptr_q, commit_ptr_q, rd_ptr_q, spec_next;
  logic [CNT_W-1:0] cnt_q, spec_q, cnt_d, spec_d, total;
  rx_op_e           op;

  // A discard outranks a commit in the same cycle.
  always_comb begin
    if (discard_i)     op = RXOP_DROP;
    else if (commit_i) op = RXOP_COMMIT;
    else               op = RXOP_IDLE;
  end

  assign total     = cnt_q + spec_q;
  assign spec_next = PTR_W'(ring_next(32'(spec_ptr_q), 32'(size_i)));
  assign wr_ok_o   = wr_en_i && !part_chg_i && (op != RXOP_DROP) && (total != size_i);
  assign rd_ok_o   = rd_en_i && !part_chg_i && (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q - CNT_W'(rd_ok_o);
    spec_d = spec_q + CNT_W'(wr_ok_o);
    case (op)
      RXOP_COMMIT: begin
        cnt_d  = cnt_d + spec_d;
        spec_d = '0;
      end
      RXOP_DROP: spec_d = '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || part_chg_i) begin
      spec_ptr_q   <= '0;
      commit_ptr_q <= '0;
      rd_ptr_q     <= '0;
      cnt_q        <= '0;
      spec_q       <= '0;
    end else begin
      cnt_q  <= cnt_d;
      spec_q <= spec_d;
      if (op == RXOP_DROP)  spec_ptr_q <= commit_ptr_q;
      else if (wr_ok_o)     spec_ptr_q <= spec_next;
      if (op == RXOP_COMMIT) commit_ptr_q <= wr_ok_o ? spec_next : spec_ptr_q;
      if (rd_ok_o) rd_ptr_q <= PTR_W'(ring_next(32'(rd_ptr_q), 32'(size_i)));
    end
  end

  assign wr_off_o = spec_ptr_q;
  assign rd_off_o = rd_ptr_q;
  assign cnt_o    = cnt_q;
  assign spec_o   = spec_q;
  assign full_o   = (total == size_i);
  assign empty_o  = (cnt_q == '0);

  assert_rx_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q + spec_q) <= size_i);

  assert_rx_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RXOP_DROP && !part_chg_i) |=>
      (spec_q == '0) && (cnt_q == $past(cnt_q) - CNT_W'($past(rd_ok_o))));

  assert_rx_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op != RXOP_COMMIT && !part_chg_i) |=> (cnt_q == $past(cnt_q) - CNT_W'($past(rd_ok_o))));

endmodule

// File: rtl/shared_mac_fifo.sv
module shared_mac_fifo
  import sfm_pkg::*;
#(
  parameter int DEPTH  = 112,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_rx_words,
  output logic [CNT_W-1:0]  part_rx_words,
  input  logic              tx_wr_en,
  input  logic [DATA_W-1:0] tx_wr_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic [CNT_W-1:0]  tx_count,
  input  logic              tx_rd_en,
  output logic [DATA_W-1:0] tx_rd_data,
  output logic              tx_rd_valid,
  output logic [CNT_W-1:0]  tx_avail,
  input  logic              tx_frame_done,
  input  logic              tx_release,
  input  logic              tx_rewind,
  output logic              tx_rewind_err,
  input  logic              rx_wr_en,
  input  logic [DATA_W-1:0] rx_wr_data,
  input  logic              rx_commit,
  input  logic              rx_discard,
  output logic              rx_full,
  input  logic              rx_rd_en,
  output logic [DATA_W-1:0] rx_rd_data,
  output logic              rx_rd_valid,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_empty
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [CNT_W-1:0] rx_words, tx_words, rx_spec;
  logic             part_chg;
  logic             tx_wr_ok, tx_rd_ok, rx_wr_ok, rx_rd_ok;
  logic [PTR_W-1:0] tx_wr_off, tx_rd_off, rx_wr_off, rx_rd_off;
  logic [PTR_W-1:0] tx_wr_addr, tx_rd_addr;
  logic             tx_valid_q, rx_valid_q;

  sfm_split #(.DEPTH(DEPTH)) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr),
    .cfg_val_i  (cfg_rx_words),
    .tx_idle_i  (tx_empty),
    .rx_idle_i  (rx_empty && (rx_spec == '0)),
    .rx_words_o (rx_words),
    .tx_words_o (tx_words),
    .part_chg_o (part_chg)
  );

  sfm_tx_ctrl #(.DEPTH(DEPTH)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .size_i       (tx_words),
    .part_chg_i   (part_chg),
    .wr_en_i      (tx_wr_en),
    .rd_en_i      (tx_rd_en),
    .done_i       (tx_frame_done),
    .release_i    (tx_release),
    .rewind_i     (tx_rewind),
    .wr_ok_o      (tx_wr_ok),
    .wr_off_o     (tx_wr_off),
    .rd_ok_o      (tx_rd_ok),
    .rd_off_o     (tx_rd_off),
    .held_o       (tx_count),
    .avail_o      (tx_avail),
    .full_o       (tx_full),
    .empty_o      (tx_empty),
    .rewind_err_o (tx_rewind_err)
  );

  sfm_rx_ctrl #(.DEPTH(DEPTH)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_i     (rx_words),
    .part_chg_i (part_chg),
    .wr_en_i    (rx_wr_en),
    .commit_i   (rx_commit),
    .discard_i  (rx_discard),
    .rd_en_i    (rx_rd_en),
    .wr_ok_o    (rx_wr_ok),
    .wr_off_o   (rx_wr_off),
    .rd_ok_o    (rx_rd_ok),
    .rd_off_o   (rx_rd_off),
    .cnt_o      (rx_count),
    .spec_o     (rx_spec),
    .full_o     (rx_full),
    .empty_o    (rx_empty)
  );

  // Receive region starts at word 0, transmit region right after it.
  assign tx_wr_addr = PTR_W'(region_addr(32'(rx_words), 32'(tx_wr_off)));
  assign tx_rd_addr = PTR_W'(region_addr(32'(rx_words), 32'(tx_rd_off)));

  sfm_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .wa_en   (rx_wr_ok),
    .wa_addr (PTR_W'(region_addr(0, 32'(rx_wr_off)))),
    .wa_data (rx_wr_data),
    .wb_en   (tx_wr_ok),
    .wb_addr (tx_wr_addr),
    .wb_data (tx_wr_data),
    .ra_en   (rx_rd_ok),
    .ra_addr (PTR_W'(region_addr(0, 32'(rx_rd_off)))),
    .ra_data (rx_rd_data),
    .rb_en   (tx_rd_ok),
    .rb_addr (tx_rd_addr),
    .rb_data (tx_rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_q <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      tx_valid_q <= tx_rd_ok;
      rx_valid_q <= rx_rd_ok;
    end
  end

  assign tx_rd_valid   = tx_valid_q;
  assign rx_rd_valid   = rx_valid_q;
  assign part_rx_words = rx_words;

  assert_split_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_words != $past(rx_words)) |->
      ($past(tx_count) == '0) && ($past(rx_count) == '0) && ($past(rx_spec) == '0));

  assert_tx_valid_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_q |-> ($past(tx_avail) != '0));

  assert_rx_valid_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> ($past(rx_count) != '0));

endmodule

// File: tb/shared_mac_fifo_tb.sv
module shared_mac_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 112;
  localparam int DW         = 32;
  localparam int CW         = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          cfg_wr;
  logic [CW-1:0] cfg_rx_words, part_rx_words;
  logic          tx_wr_en, tx_full, tx_empty, tx_rd_en, tx_rd_valid;
  logic [DW-1:0] tx_wr_data, tx_rd_data;
  logic [CW-1:0] tx_count, tx_avail;
  logic          tx_frame_done, tx_release, tx_rewind, tx_rewind_err;
  logic          rx_wr_en, rx_commit, rx_discard, rx_full, rx_rd_en, rx_rd_valid, rx_empty;
  logic [DW-1:0] rx_wr_data, rx_rd_data;
  logic [CW-1:0] rx_count;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shared_mac_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Scoreboards and independent models.
  logic [DW-1:0] sb_tx[$], sb_rx[$];
  logic [DW-1:0] m_tx[$], m_rx_c[$], m_rx_s[$];
  int tx_idx = 0;
  bit trimmed = 0;
  int rx_cap = DEPTH / 2;

  function automatic int tx_cap();
    return DEPTH - rx_cap;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compares each returned word with the head of its scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_rd_valid) begin
        n_chk++;
        if (sb_tx.size() == 0) begin
          n_fail++;
          $display("FAIL R2 tx unexpected word actual=%h expected=none", tx_rd_data);
        end else begin
          logic [DW-1:0] e;
          e = sb_tx.pop_front();
          if (tx_rd_data !== e) begin
            n_fail++;
            $display("FAIL R2/R3 tx word actual=%h expected=%h", tx_rd_data, e);
          end
        end
      end
      if (rx_rd_valid) begin
        n_chk++;
        if (sb_rx.size() == 0) begin
          n_fail++;
          $display("FAIL R8 rx unexpected word actual=%h expected=none", rx_rd_data);
        end else begin
          logic [DW-1:0] e;
          e = sb_rx.pop_front();
          if (rx_rd_data !== e) begin
            n_fail++;
            $display("FAIL R8 rx word actual=%h expected=%h", rx_rd_data, e);
          end
        end
      end
    end
  end

  task automatic clear_in();
    cfg_wr = 0; cfg_rx_words = '0;
    tx_wr_en = 0; tx_wr_data = '0; tx_rd_en = 0;
    tx_frame_done = 0; tx_release = 0; tx_rewind = 0;
    rx_wr_en = 0; rx_wr_data = '0; rx_commit = 0; rx_discard = 0; rx_rd_en = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic tx_put(input logic [DW-1:0] d);
    tx_wr_en = 1; tx_wr_data = d;
    if (m_tx.size() < tx_cap()) m_tx.push_back(d);
    step();
  endtask

  task automatic tx_get();
    tx_rd_en = 1;
    if (tx_idx < m_tx.size()) begin
      sb_tx.push_back(m_tx[tx_idx]);
      tx_idx++;
    end
    step();
  endtask

  task automatic tx_free(input bit early);
    if (early) tx_release = 1; else tx_frame_done = 1;
    repeat (tx_idx) void'(m_tx.pop_front());
    tx_idx = 0;
    trimmed = early;
    step();
  endtask

  task automatic tx_rew();
    bit exp_err;
    exp_err = trimmed;
    tx_rewind = 1;
    if (!trimmed) tx_idx = 0;
    step();
    chk("R5 rewind_err pulse", tx_rewind_err, exp_err);
  endtask

  task automatic rx_put(input logic [DW-1:0] d, input bit com, input bit dis);
    rx_wr_en = 1; rx_wr_data = d; rx_commit = com; rx_discard = dis;
    if (!dis && (m_rx_c.size() + m_rx_s.size() < rx_cap)) m_rx_s.push_back(d);
    if (dis) m_rx_s.delete();
    else if (com) begin
      foreach (m_rx_s[i]) m_rx_c.push_back(m_rx_s[i]);
      m_rx_s.delete();
    end
    step();
  endtask

  task automatic rx_ctl(input bit com, input bit dis);
    rx_commit = com; rx_discard = dis;
    if (dis) m_rx_s.delete();
    else if (com) begin
      foreach (m_rx_s[i]) m_rx_c.push_back(m_rx_s[i]);
      m_rx_s.delete();
    end
    step();
  endtask

  task automatic rx_get();
    rx_rd_en = 1;
    if (m_rx_c.size() > 0) sb_rx.push_back(m_rx_c.pop_front());
    step();
  endtask

  task automatic set_split(input int v);
    cfg_wr = 1; cfg_rx_words = CW'(v);
    if (m_tx.size() == 0 && m_rx_c.size() == 0 && m_rx_s.size() == 0 && v >= 1 && v < DEPTH)
      rx_cap = v;
    step();
    chk("R9 split value", part_rx_words, rx_cap);
  endtask

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 split", part_rx_words, DEPTH / 2);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 rx_full", rx_full, 0);

    // R2 / R4: plain frame
    for (int i = 0; i < 5; i++) tx_put(32'hA000_0000 + i);
    chk("R2 tx_count after writes", tx_count, 5);
    for (int i = 0; i < 5; i++) tx_get();
    chk("R4 tx_count before done", tx_count, 5);
    chk("R2 tx_avail drained", tx_avail, 0);
    tx_free(0);
    chk("R4 tx_count after done", tx_count, 0);

    // R3: replay after collision
    for (int i = 0; i < 4; i++) tx_put(32'hB000_0000 + i);
    for (int i = 0; i < 3; i++) tx_get();
    tx_rew();
    chk("R3 tx_avail after rewind", tx_avail, 4);
    for (int i = 0; i < 4; i++) tx_get();
    tx_free(0);
    chk("R4 tx_count frame two", tx_count, 0);

    // R5: early release then refused rewind
    for (int i = 0; i < 6; i++) tx_put(32'hC000_0000 + i);
    tx_get(); tx_get();
    tx_free(1);
    chk("R5 tx_count after release", tx_count, 4);
    tx_rew();
    step();
    chk("R5 rewind_err one cycle", tx_rewind_err, 0);
    for (int i = 0; i < 4; i++) tx_get();
    tx_free(0);
    tx_put(32'hC100_0000); tx_put(32'hC100_0001);
    tx_get();
    tx_rew();
    tx_get(); tx_get();
    tx_free(0);

    // R11: rewind with read and done in the same cycle
    for (int i = 0; i < 3; i++) tx_put(32'hD000_0000 + i);
    tx_get();
    tx_rewind = 1; tx_rd_en = 1; tx_frame_done = 1;
    tx_idx = 0;
    step();
    chk("R11 tx_count kept", tx_count, 3);
    chk("R11 tx_avail restored", tx_avail, 3);
    for (int i = 0; i < 3; i++) tx_get();
    tx_free(0);

    // R2: full transmit side
    for (int i = 0; i < tx_cap(); i++) tx_put(32'hE000_0000 + i);
    chk("R2 tx_full", tx_full, 1);
    tx_put(32'hEEEE_EEEE);
    chk("R2 tx_count capped", tx_count, tx_cap());
    while (tx_idx < m_tx.size()) tx_get();
    tx_free(0);
    chk("R2 tx_empty after drain", tx_empty, 1);

    // R6: hidden until commit, commit includes same-cycle write
    rx_put(32'h1000_0000, 0, 0);
    rx_put(32'h1000_0001, 0, 0);
    rx_put(32'h1000_0002, 0, 0);
    chk("R6 rx_count before commit", rx_count, 0);
    chk("R6 rx_empty before commit", rx_empty, 1);
    rx_put(32'h1000_0003, 1, 0);
    chk("R6 rx_count after commit", rx_count, 4);
    for (int i = 0; i < 4; i++) rx_get();

    // R7: discard with write, discard beats commit
    rx_put(32'h2000_0000, 0, 0);
    rx_put(32'h2000_0001, 0, 0);
    rx_put(32'h2000_0002, 0, 1);
    chk("R7 rx_count after discard", rx_count, 0);
    rx_put(32'h2100_0000, 0, 0);
    rx_ctl(1, 1);
    chk("R7 discard over commit", rx_count, 0);
    rx_put(32'h2200_0000, 0, 0);
    rx_put(32'h2200_0001, 1, 0);
    chk("R7 committed kept", rx_count, 2);
    rx_put(32'h2300_0000, 0, 0);
    rx_ctl(0, 1);
    chk("R7 committed unaffected", rx_count, 2);
    rx_get(); rx_get();

    // R8: receive full
    for (int i = 0; i < rx_cap; i++) rx_put(32'h3000_0000 + i, 0, 0);
    chk("R8 rx_full", rx_full, 1);
    rx_put(32'h3FFF_FFFF, 0, 0);
    rx_ctl(1, 0);
    chk("R8 rx_count capped", rx_count, rx_cap);
    while (m_rx_c.size() > 0) rx_get();
    chk("R8 rx_empty after drain", rx_empty, 1);

    // R9: boundary lock and range
    tx_put(32'h4000_0000);
    set_split(20);
    tx_get(); tx_free(0);
    rx_put(32'h4100_0000, 0, 0);
    set_split(20);
    rx_ctl(0, 1);
    set_split(0);
    set_split(DEPTH);
    set_split(20);
    chk("R9 rx side size", part_rx_words, 20);

    // R10: wrap with an uneven split
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 15; i++) rx_put(32'h5000_0000 + r * 256 + i, 0, 0);
      rx_ctl(1, 0);
      chk("R10 rx_count per round", rx_count, 15);
      for (int i = 0; i < 15; i++) rx_get();
    end
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 40; i++) tx_put(32'h6000_0000 + r * 256 + i);
      for (int i = 0; i < 40; i++) tx_get();
      tx_free(0);
    end
    for (int i = 0; i < tx_cap(); i++) tx_put(32'h7000_0000 + i);
    chk("R10 tx_full at new size", tx_full, 1);
    chk("R10 tx_count at new size", tx_count, 92);
    while (tx_idx < m_tx.size()) tx_get();
    tx_free(0);

    repeat (3) step();
    chk("R2 tx scoreboard drained", sb_tx.size(), 0);
    chk("R8 rx scoreboard drained", sb_rx.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule